// File: doc/BRIEF.md
# Linked Descriptor Plane Fetcher

This block drives the settings of a single graphics layer from a chain of descriptors held in memory. Software builds each descriptor as a block of sixteen 32-bit words and links descriptors through a next-node word. Usually a top-field and a bottom-field descriptor point at each other. At every vertical sync the block reads the descriptor named by its chain pointer through a simple read port. It keeps only the words it presents, and it moves all presented fields into the active shadow registers in one cycle. The chain pointer then takes the link word, so the following sync walks to the next descriptor.

Software can redirect the chain at any time by writing the pointer. A write wins over the link of a fetch already in progress, which gives an atomic bank swap. Bit 31 of the control word defers a fetched descriptor: it is parked and applied at the following sync. A small status register collects sticky error flags. Pixel fetch, format conversion and blending belong to other blocks. This one only presents the active fields, the format code, a visibility flag and the field parity seen at the last sync.

Top module: `layer_chain_fetch`

## Requirements
- R1: After reset every presented field is zero, `visible_o` is 0, the pointer and status registers read 0, and no memory request is made.
- R2: On a sync, if the walker is idle and the pointer is non-zero with its low four bits clear, the block reads 16 words at pointer+4*k for k = 0..15 in increasing order. It keeps only one request outstanding: `mem_req_o` is a single-cycle pulse, and the next request waits for `mem_rvalid_i`.
- R3: A sync with a zero pointer starts no fetch.
- R4: A sync with a pointer whose low four bits are not all zero starts no fetch and sets sticky status bit 2.
- R5: The shadow updates in one cycle, and only after the last word has arrived. It takes control from word 0, viewport start from word 3, viewport stop from word 4, pixel base from word 5, pitch from word 6 and size from word 7. `fmt_o` equals control bits 4:0.
- R6: When a fetch completes, the pointer takes the link word (word 9) of the fetched descriptor, so two descriptors that are linked to each other alternate on successive syncs.
- R7: A pointer write (`reg_sel_i`=0) reads back in the next cycle. If the write happens during a fetch, the link of that fetch is discarded.
- R8: A fetched descriptor with control bit 31 set does not change the presented fields when its fetch completes. It becomes active at the next sync.
- R9: `visible_o` is 1 only when a descriptor is active and bits 1:0 of its properties word (word 13) are both 0.
- R10: A sync during a fetch starts no new fetch and leaves the presented fields unchanged at that sync. It sets sticky status bit 1.
- R11: `underflow_i` sets sticky status bit 0. Writing the status register (`reg_sel_i`=1) clears each of bits 2:0 whose write bit is 1 and leaves the others unchanged.
- R12: `field_bot_o` takes the value of `field_bot_i` at each sync and holds it between syncs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Vertical sync, one-cycle pulse |
| field_bot_i | input | 1 | Field parity at sync: 1 bottom, 0 top |
| underflow_i | input | 1 | Underflow event from the pixel path |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 pointer, 1 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| mem_req_o | output | 1 | Descriptor word read request |
| mem_addr_o | output | ADDR_W | Byte address of the requested word |
| mem_rdata_i | input | 32 | Returned descriptor word |
| mem_rvalid_i | input | 1 | Returned word is valid |
| ctrl_o | output | 32 | Active control word |
| fmt_o | output | 5 | Active pixel-format code |
| vp_start_o | output | 32 | Active viewport start |
| vp_stop_o | output | 32 | Active viewport stop |
| pix_base_o | output | 32 | Active pixel memory base |
| pitch_o | output | 32 | Active line pitch |
| size_o | output | 32 | Active source size |
| visible_o | output | 1 | Layer shown on the mixer |
| field_bot_o | output | 1 | Field parity latched at the last sync |

## Verification
Several rules are checked by assertions on every cycle:
- the read port never has more than one request outstanding;
- a zero or misaligned pointer never leads to a request;
- the shadow, the parity flag and the pointer move only on their own triggers;
- a deferred descriptor leaves the active fields untouched;
- the sticky flags hold until they are cleared.

Other behaviour can only be shown by the bench's scenarios. These are the exact word-to-field mapping, the address sequence, alternation through the link words, and software overriding a link in the middle of a fetch. They also cover a deferred descriptor appearing one sync later and the count of requests after an overrun.

// File: rtl/lcf_pkg.sv
package lcf_pkg;
  localparam int unsigned DESC_WORDS     = 16;
  localparam int unsigned IDX_W          = $clog2(DESC_WORDS);
  localparam int unsigned ALIGN_BITS     = 4;
  localparam int unsigned HIDE_BITS      = 2;
  localparam int unsigned STAT_BITS      = 3;
  localparam int unsigned CTRL_DEFER_BIT = 31;
  localparam int unsigned FMT_W          = 5;

  // word positions inside one descriptor
  localparam int unsigned W_CTRL    = 0;
  localparam int unsigned W_VPSTART = 3;
  localparam int unsigned W_VPSTOP  = 4;
  localparam int unsigned W_PIXBASE = 5;
  localparam int unsigned W_PITCH   = 6;
  localparam int unsigned W_SIZE    = 7;
  localparam int unsigned W_LINK    = 9;
  localparam int unsigned W_PROPS   = 13;

  // status bit positions
  localparam int unsigned ST_UFLOW   = 0;
  localparam int unsigned ST_OVERRUN = 1;
  localparam int unsigned ST_ALIGN   = 2;

  typedef struct packed {
    logic [31:0]          ctrl;
    logic [31:0]          vp_start;
    logic [31:0]          vp_stop;
    logic [31:0]          pix_base;
    logic [31:0]          pitch;
    logic [31:0]          size;
    logic [HIDE_BITS-1:0] hide;
  } shadow_t;

  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_REQ  = 2'd1,
    WK_WAIT = 2'd2
  } walk_st_e;
endpackage

// File: rtl/lcf_walker.sv
module lcf_walker
  import lcf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vsync_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              mem_rvalid_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              word_we_o,
  output logic [IDX_W-1:0]  word_idx_o,
  output logic              fetch_done_o,
  output logic              busy_o,
  output logic              overrun_o,
  output logic              misalign_o
);
  walk_st_e          st_q, st_d;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              idx_en, base_en;
  logic              idle, ptr_ok, start, last;

  assign idle   = (st_q == WK_IDLE);
  assign ptr_ok = (ptr_i != '0) && (ptr_i[ALIGN_BITS-1:0] == '0);
  assign start  = vsync_i && idle && ptr_ok;
  assign last   = (idx_q == IDX_W'(DESC_WORDS - 1));

  assign word_we_o    = (st_q == WK_WAIT) && mem_rvalid_i;
  assign fetch_done_o = word_we_o && last;
  assign overrun_o    = vsync_i && !idle;
  assign misalign_o   = vsync_i && idle && (ptr_i[ALIGN_BITS-1:0] != '0);
  assign busy_o       = !idle;
  assign mem_req_o    = (st_q == WK_REQ);
  assign mem_addr_o   = base_q + ADDR_W'({idx_q, 2'b00});
  assign word_idx_o   = idx_q;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    base_en = 1'b0;
    unique case (st_q)
      WK_IDLE: begin
        if (start) begin
          st_d    = WK_REQ;
          idx_d   = '0;
          idx_en  = 1'b1;
          base_en = 1'b1;
        end
      end
      WK_REQ: st_d = WK_WAIT;
      WK_WAIT: begin
        if (mem_rvalid_i) begin
          if (last) begin
            st_d = WK_IDLE;
          end else begin
            st_d   = WK_REQ;
            idx_d  = idx_q + 1'b1;
            idx_en = 1'b1;
          end
        end
      end
      default: st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= WK_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      base_q <= '0;
    else if (base_en) base_q <= ptr_i;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R2
  AST_NO_BAD_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsync_i && idle && !ptr_ok) |=> !mem_req_o); // R3
  AST_NO_RESTART_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsync_i && !idle) |=> $stable(base_q)); // R10
endmodule

// File: rtl/lcf_collect.sv
module lcf_collect
  import lcf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             word_we_i,
  input  logic [IDX_W-1:0] word_idx_i,
  input  logic [31:0]      word_i,
  output shadow_t          stage_o,
  output logic [31:0]      link_o
);
  shadow_t     stage_q;
  logic [31:0] link_q;
  logic        en_ctrl, en_vps, en_vpe, en_pix, en_pitch, en_size, en_link, en_props;

  always_comb begin
    en_ctrl  = word_we_i && (word_idx_i == IDX_W'(W_CTRL));
    en_vps   = word_we_i && (word_idx_i == IDX_W'(W_VPSTART));
    en_vpe   = word_we_i && (word_idx_i == IDX_W'(W_VPSTOP));
    en_pix   = word_we_i && (word_idx_i == IDX_W'(W_PIXBASE));
    en_pitch = word_we_i && (word_idx_i == IDX_W'(W_PITCH));
    en_size  = word_we_i && (word_idx_i == IDX_W'(W_SIZE));
    en_link  = word_we_i && (word_idx_i == IDX_W'(W_LINK));
    en_props = word_we_i && (word_idx_i == IDX_W'(W_PROPS));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      link_q  <= '0;
    end else begin
      if (en_ctrl)  stage_q.ctrl     <= word_i;
      if (en_vps)   stage_q.vp_start <= word_i;
      if (en_vpe)   stage_q.vp_stop  <= word_i;
      if (en_pix)   stage_q.pix_base <= word_i;
      if (en_pitch) stage_q.pitch    <= word_i;
      if (en_size)  stage_q.size     <= word_i;
      if (en_props) stage_q.hide     <= word_i[HIDE_BITS-1:0];
      if (en_link)  link_q           <= word_i;
    end
  end

  assign stage_o = stage_q;
  assign link_o  = link_q;

  AST_STAGE_ONLY_ON_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_we_i |=> $stable(stage_q)); // R5
endmodule

// File: rtl/lcf_shadow.sv
module lcf_shadow
  import lcf_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    vsync_i,
  input  logic    field_bot_i,
  input  logic    fetch_done_i,
  input  shadow_t stage_i,
  output shadow_t act_o,
  output logic    visible_o,
  output logic    field_bot_o
);
  shadow_t act_q, act_d, pend_q;
  logic    act_v_q, pend_v_q, pend_v_d, fld_q;
  logic    defer, from_stage, from_pend, act_en, pend_en;

  assign defer      = stage_i.ctrl[CTRL_DEFER_BIT];
  assign from_stage = fetch_done_i && !defer;
  assign from_pend  = vsync_i && pend_v_q;
  assign pend_en    = fetch_done_i && defer;
  assign act_en     = from_stage || from_pend;

  always_comb begin
    act_d    = from_stage ? stage_i : pend_q;
    pend_v_d = pend_v_q;
    if (from_pend) pend_v_d = 1'b0;
    if (pend_en)   pend_v_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= '0;
      act_v_q <= 1'b0;
    end else if (act_en) begin
      act_q   <= act_d;
      act_v_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= '0;
    else if (pend_en) pend_q <= stage_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_v_q <= 1'b0;
    else         pend_v_q <= pend_v_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fld_q <= 1'b0;
    else if (vsync_i) fld_q <= field_bot_i;
  end

  assign act_o       = act_q;
  assign visible_o   = act_v_q && (act_q.hide == '0);
  assign field_bot_o = fld_q;

  AST_SHADOW_ATOMIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vsync_i && !fetch_done_i) |=> $stable(act_q)); // R5
  AST_DEFER_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_done_i && defer && !vsync_i) |=> $stable(act_q)); // R8
  AST_FIELD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_i |=> $stable(fld_q)); // R12
endmodule

// File: rtl/lcf_regs.sv
module lcf_regs
  import lcf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              fetch_done_i,
  input  logic              busy_i,
  input  logic [31:0]       link_i,
  input  logic              underflow_i,
  input  logic              overrun_i,
  input  logic              misalign_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [31:0]       reg_rdata_o
);
  logic [ADDR_W-1:0]    ptr_q, ptr_d;
  logic                 ptr_en, hold_q, hold_d;
  logic [STAT_BITS-1:0] stat_q, stat_d, stat_set, stat_clr;
  logic                 sw_ptr_wr, sw_stat_wr, take_link;

  assign sw_ptr_wr  = reg_we_i && !reg_sel_i;
  assign sw_stat_wr = reg_we_i && reg_sel_i;
  assign take_link  = fetch_done_i && !hold_q;

  always_comb begin
    ptr_en = sw_ptr_wr || take_link;
    ptr_d  = sw_ptr_wr ? reg_wdata_i[ADDR_W-1:0] : link_i[ADDR_W-1:0];

    hold_d = hold_q;
    if (sw_ptr_wr && busy_i) hold_d = 1'b1;
    if (fetch_done_i)        hold_d = 1'b0;

    stat_set             = '0;
    stat_set[ST_UFLOW]   = underflow_i;
    stat_set[ST_OVERRUN] = overrun_i;
    stat_set[ST_ALIGN]   = misalign_i;
    stat_clr = sw_stat_wr ? reg_wdata_i[STAT_BITS-1:0] : '0;
    stat_d   = (stat_q & ~stat_clr) | stat_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= hold_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign ptr_o       = ptr_q;
  assign reg_rdata_o = reg_sel_i ? 32'(stat_q) : 32'(ptr_q);

  AST_SW_PTR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_ptr_wr |=> (ptr_q == $past(reg_wdata_i[ADDR_W-1:0]))); // R7
  AST_SW_BEATS_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_done_i && hold_q && !sw_ptr_wr) |=> $stable(ptr_q)); // R7
  AST_OVERRUN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_i |=> stat_q[ST_OVERRUN]); // R10
  AST_UFLOW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[ST_UFLOW] && !(sw_stat_wr && reg_wdata_i[ST_UFLOW])) |=> stat_q[ST_UFLOW]); // R11
endmodule

// File: rtl/layer_chain_fetch.sv
module layer_chain_fetch
  import lcf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vsync_i,
  input  logic              field_bot_i,
  input  logic              underflow_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_rvalid_i,
  output logic [31:0]       ctrl_o,
  output logic [FMT_W-1:0]  fmt_o,
  output logic [31:0]       vp_start_o,
  output logic [31:0]       vp_stop_o,
  output logic [31:0]       pix_base_o,
  output logic [31:0]       pitch_o,
  output logic [31:0]       size_o,
  output logic              visible_o,
  output logic              field_bot_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic [ADDR_W-1:0] ptr;
  logic              word_we, fetch_done, busy, overrun, misalign;
  logic [IDX_W-1:0]  word_idx;
  shadow_t           stage, act;
  logic [31:0]       link;

  // reset asserts at once and releases on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  lcf_walker #(.ADDR_W(ADDR_W)) walker_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .vsync_i      (vsync_i),
    .ptr_i        (ptr),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .word_we_o    (word_we),
    .word_idx_o   (word_idx),
    .fetch_done_o (fetch_done),
    .busy_o       (busy),
    .overrun_o    (overrun),
    .misalign_o   (misalign)
  );

  lcf_collect collect_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .word_we_i  (word_we),
    .word_idx_i (word_idx),
    .word_i     (mem_rdata_i),
    .stage_o    (stage),
    .link_o     (link)
  );

  lcf_shadow shadow_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .vsync_i      (vsync_i),
    .field_bot_i  (field_bot_i),
    .fetch_done_i (fetch_done),
    .stage_i      (stage),
    .act_o        (act),
    .visible_o    (visible_o),
    .field_bot_o  (field_bot_o)
  );

  lcf_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .reg_we_i     (reg_we_i),
    .reg_sel_i    (reg_sel_i),
    .reg_wdata_i  (reg_wdata_i),
    .fetch_done_i (fetch_done),
    .busy_i       (busy),
    .link_i       (link),
    .underflow_i  (underflow_i),
    .overrun_i    (overrun),
    .misalign_i   (misalign),
    .ptr_o        (ptr),
    .reg_rdata_o  (reg_rdata_o)
  );

  assign ctrl_o     = act.ctrl;
  assign fmt_o      = act.ctrl[FMT_W-1:0];
  assign vp_start_o = act.vp_start;
  assign vp_stop_o  = act.vp_stop;
  assign pix_base_o = act.pix_base;
  assign pitch_o    = act.pitch;
  assign size_o     = act.size;
endmodule

// File: tb/layer_chain_fetch_tb_top.sv
module layer_chain_fetch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        vsync, field_bot, underflow;
  logic        reg_we, reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr, mem_rdata;
  logic        mem_rvalid;
  logic [31:0] ctrl, vp_start, vp_stop, pix_base, pitch, size;
  logic [4:0]  fmt;
  logic        visible, field_bot_out;

  int total = 0;
  int bad   = 0;
  int nreq  = 0;
  logic finished = 1'b0;
  logic [31:0] addr_log [256];
  logic [31:0] mem [64];
  logic        rq1;
  logic [5:0]  ra1;

  always #2.5 clk = ~clk;

  layer_chain_fetch dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .vsync_i      (vsync),
    .field_bot_i  (field_bot),
    .underflow_i  (underflow),
    .reg_we_i     (reg_we),
    .reg_sel_i    (reg_sel),
    .reg_wdata_i  (reg_wdata),
    .reg_rdata_o  (reg_rdata),
    .mem_req_o    (mem_req),
    .mem_addr_o   (mem_addr),
    .mem_rdata_i  (mem_rdata),
    .mem_rvalid_i (mem_rvalid),
    .ctrl_o       (ctrl),
    .fmt_o        (fmt),
    .vp_start_o   (vp_start),
    .vp_stop_o    (vp_stop),
    .pix_base_o   (pix_base),
    .pitch_o      (pitch),
    .size_o       (size),
    .visible_o    (visible),
    .field_bot_o  (field_bot_out)
  );

  // memory model: data returns two cycles after the request
  always @(posedge clk) begin
    if (!rst_n) begin
      rq1        <= 1'b0;
      ra1        <= '0;
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      rq1        <= mem_req;
      ra1        <= mem_addr[7:2];
      mem_rvalid <= rq1;
      mem_rdata  <= mem[ra1];
    end
  end

  always @(posedge clk) begin
    if (rst_n && mem_req) begin
      if (nreq < 256) addr_log[nreq] <= mem_addr;
      nreq <= nreq + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic sel, output logic [31:0] data);
    reg_sel = sel;
    #1;
    data = reg_rdata;
  endtask

  task automatic pulse_vsync(input logic bot);
    @(negedge clk);
    vsync = 1'b1; field_bot = bot;
    @(negedge clk);
    vsync = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fill_desc(input int b, input logic [31:0] c, input logic [31:0] vs,
                           input logic [31:0] ve, input logic [31:0] px,
                           input logic [31:0] pt, input logic [31:0] sz,
                           input logic [31:0] lk, input logic [31:0] pr);
    mem[b+0] = c;  mem[b+3] = vs; mem[b+4] = ve; mem[b+5] = px;
    mem[b+6] = pt; mem[b+7] = sz; mem[b+9] = lk; mem[b+13] = pr;
  endtask

  task automatic test_reset;
    logic [31:0] r;
    chk("R1 ctrl", ctrl, 32'h0);
    chk("R1 pix_base", pix_base, 32'h0);
    chk("R1 visible", {31'b0, visible}, 32'h0);
    reg_read(1'b0, r); chk("R1 pointer", r, 32'h0);
    reg_read(1'b1, r); chk("R1 status", r, 32'h0);
    chk("R1 no request", nreq, 0);
  endtask

  task automatic test_zero_ptr;
    int n0;
    n0 = nreq;
    pulse_vsync(1'b0);
    wait_cyc(30);
    chk("R3 no fetch on zero pointer", nreq - n0, 0);
  endtask

  task automatic test_misaligned;
    int n0;
    logic [31:0] r;
    reg_write(1'b0, 32'h44);
    n0 = nreq;
    pulse_vsync(1'b0);
    wait_cyc(30);
    chk("R4 no fetch on misaligned pointer", nreq - n0, 0);
    reg_read(1'b1, r); chk("R4 align flag", r, 32'h4);
    reg_write(1'b1, 32'h4);
    reg_read(1'b1, r); chk("R11 align flag cleared", r, 32'h0);
  endtask

  task automatic test_chain;
    int n0;
    logic [31:0] r;
    logic addr_ok;
    reg_write(1'b0, 32'h40);
    n0 = nreq;
    pulse_vsync(1'b1);
    chk("R12 field latched bottom", {31'b0, field_bot_out}, 32'h1);
    wait_cyc(150);
    chk("R2 request count", nreq - n0, 16);
    addr_ok = 1'b1;
    for (int k = 0; k < 16; k++)
      if (addr_log[n0 + k] !== 32'h40 + 32'(4 * k)) addr_ok = 1'b0;
    chk("R2 address sequence", {31'b0, addr_ok}, 32'h1);
    chk("R5 ctrl A", ctrl, 32'h0000_0005);
    chk("R5 fmt A", {27'b0, fmt}, 32'h5);
    chk("R5 vp_start A", vp_start, 32'h0010_0020);
    chk("R5 vp_stop A", vp_stop, 32'h0100_0200);
    chk("R5 pix_base A", pix_base, 32'h1000_0000);
    chk("R5 pitch A", pitch, 32'h0000_0800);
    chk("R5 size A", size, 32'h00F0_0140);
    chk("R9 A visible", {31'b0, visible}, 32'h1);
    reg_read(1'b0, r); chk("R6 pointer follows link of A", r, 32'h80);
    pulse_vsync(1'b0);
    chk("R12 field latched top", {31'b0, field_bot_out}, 32'h0);
    wait_cyc(20);
    chk("R5 no change mid-fetch", ctrl, 32'h0000_0005);
    wait_cyc(130);
    chk("R6 B ctrl", ctrl, 32'h0000_0007);
    chk("R6 B pix_base", pix_base, 32'h2000_0000);
    chk("R9 B hidden by props bit0", {31'b0, visible}, 32'h0);
    reg_read(1'b0, r); chk("R6 pointer back to A", r, 32'h40);
  endtask

  task automatic test_sw_override;
    logic [31:0] r;
    pulse_vsync(1'b1);
    wait_cyc(10);
    reg_write(1'b0, 32'hC0);
    reg_read(1'b0, r); chk("R7 readback after write", r, 32'hC0);
    wait_cyc(150);
    reg_read(1'b0, r); chk("R7 write beats link", r, 32'hC0);
    chk("R7 fetched A applied", ctrl, 32'h0000_0005);
  endtask

  task automatic test_defer;
    logic [31:0] r;
    pulse_vsync(1'b0);
    wait_cyc(150);
    chk("R8 deferred not applied", ctrl, 32'h0000_0005);
    reg_read(1'b0, r); chk("R6 self link", r, 32'hC0);
    pulse_vsync(1'b1);
    chk("R8 deferred applied at sync", ctrl, 32'h8000_0002);
    chk("R8 fmt C", {27'b0, fmt}, 32'h2);
    chk("R9 C hidden by props bit1", {31'b0, visible}, 32'h0);
    wait_cyc(150);
  endtask

  task automatic test_overrun;
    int n0;
    logic [31:0] r, held;
    reg_write(1'b0, 32'h40);
    n0 = nreq;
    pulse_vsync(1'b0);
    wait_cyc(10);
    held = ctrl;
    pulse_vsync(1'b1);
    chk("R10 shadow held at overrun", ctrl, held);
    reg_read(1'b1, r); chk("R10 overrun flag", r, 32'h2);
    wait_cyc(150);
    chk("R10 no second fetch", nreq - n0, 16);
    chk("R10 first fetch applied", ctrl, 32'h0000_0005);
    reg_write(1'b1, 32'h2);
    reg_read(1'b1, r); chk("R11 overrun cleared", r, 32'h0);
  endtask

  task automatic test_underflow;
    logic [31:0] r;
    @(negedge clk); underflow = 1'b1;
    @(negedge clk); underflow = 1'b0;
    wait_cyc(5);
    reg_read(1'b1, r); chk("R11 underflow sticky", r, 32'h1);
    reg_write(1'b1, 32'h0);
    reg_read(1'b1, r); chk("R11 zero write keeps flag", r, 32'h1);
    reg_write(1'b1, 32'h1);
    reg_read(1'b1, r); chk("R11 flag cleared", r, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; vsync = 1'b0; field_bot = 1'b0; underflow = 1'b0;
    reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    for (int k = 0; k < 64; k++) mem[k] = 32'hBAD0_0000 | 32'(k);
    fill_desc(16, 32'h0000_0005, 32'h0010_0020, 32'h0100_0200, 32'h1000_0000,
              32'h0000_0800, 32'h00F0_0140, 32'h80, 32'h0);
    fill_desc(32, 32'h0000_0007, 32'h0011_0021, 32'h0111_0211, 32'h2000_0000,
              32'h0000_0400, 32'h0050_0060, 32'h40, 32'h1);
    fill_desc(48, 32'h8000_0002, 32'h0012_0022, 32'h0122_0222, 32'h3000_0000,
              32'h0000_0200, 32'h0030_0040, 32'hC0, 32'h2);
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    test_reset();
    test_zero_ptr();
    test_misaligned();
    test_chain();
    test_sw_override();
    test_defer();
    test_overrun();
    test_underflow();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule